// File: doc/BRIEF.md
# Conversion Mode and Ready Controller

This block holds the operating mode of a converter and the ready flag that a serial interface shows to the host. It reads configuration writes, the completion pulses of the conversion engine and the pulses that say a result has been consumed. From these it issues conversion-start requests, keeps the latest result and keeps the mode and ready bits. Two modes are supported: one-shot and continuous.

The ready bit has two jobs. When the host writes it, it is a one-shot start command. When the host reads it, it is a data-not-ready flag. In continuous mode it drops when a result arrives and rises again once that result is consumed. In one-shot mode it stays low after the result is consumed, until the host writes a new command.

Result data flows in as a valid-only stream. `conv_done` is the valid strobe and there is no back-pressure, so a result is taken in every cycle that `conv_done` is high. Each new result overwrites the stored one, whether or not the previous result was consumed. All outputs are registered and change one cycle after the input that causes them.

Top module: `convmode_ctrl`

## Requirements
- R1: While reset is held, `mode_cont`=1, `rdy`=1, `result`=0 and `conv_start`=0. In the first cycle after reset is released, `conv_start` pulses once.
- R2: A write with `cfg_wdata[4]`=1 selects continuous mode, whatever the value of `cfg_wdata[7]`. In the next cycle `mode_cont`=1, `rdy`=1 and `conv_start`=1.
- R3: A write with `cfg_wdata[4]`=0 and `cfg_wdata[7]`=1 starts a single conversion. In the next cycle `mode_cont`=0, `rdy`=1 and `conv_start`=1.
- R4: A write with `cfg_wdata[4]`=0 and `cfg_wdata[7]`=0 selects one-shot mode and starts nothing. `rdy` and `result` are unchanged by it, and `conv_start` stays low. In one-shot mode such a write has no visible effect.
- R5: A `conv_done` pulse stores `conv_data` into `result` by the next cycle, in either mode and whatever else happens in that cycle.
- R6: A `conv_done` pulse in continuous mode clears `rdy` and raises `conv_start` in the next cycle. The mode used here is the one in force after any write in the same cycle.
- R7: In one-shot mode, `conv_done` clears `rdy` but raises no `conv_start`. A `rd_done` pulse leaves `rdy` unchanged.
- R8: In continuous mode, a `rd_done` pulse with no `conv_done` in the same cycle sets `rdy` high in the next cycle.
- R9: When `conv_done` and `rd_done` arrive in the same cycle, `rdy` is low in the next cycle.
- R10: When a start write (R2 or R3) and `conv_done` arrive in the same cycle, `rdy` ends high and `result` still takes the new data.
- R11: In a cycle with no write, no `conv_done` and no `rd_done`, all outputs hold and `conv_start` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration byte: bit 4 selects the mode, bit 7 is the start/ready bit |
| conv_done | input | 1 | Conversion complete; valid strobe for `conv_data` |
| conv_data | input | RES_W | New conversion result |
| rd_done | input | 1 | Stored result has been consumed by the serial side |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| result | output | RES_W | Latest conversion result |
| mode_cont | output | 1 | 1 = continuous mode, 0 = one-shot mode |
| rdy | output | 1 | Ready bit as read by the host; low means a fresh result is waiting |

## Verification
The assertions assume that `conv_done` and `rd_done` are single-cycle strobes, that inputs are known after reset, and that `conv_data` is meaningful only while `conv_done` is high. Several of the properties leave out cycles where a write and another event coincide, because their priority is covered by R10 and by the bench. The stimulus drives every input at the falling edge from a seeded random stream. It combines writes, completions and reads in all patterns, including coincidences, and directed cases pin down each command encoding and collision.

// File: rtl/convmode_pkg.sv
package convmode_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_KEEP    = 2'd1,
    CMD_ONESHOT = 2'd2,
    CMD_CONT    = 2'd3
  } cfg_cmd_e;

  function automatic logic cmd_starts(input cfg_cmd_e c);
    return (c == CMD_ONESHOT) || (c == CMD_CONT);
  endfunction

  function automatic logic cmd_writes(input cfg_cmd_e c);
    return c != CMD_NONE;
  endfunction

endpackage

// File: rtl/convmode_cfg_decode.sv
module convmode_cfg_decode
  import convmode_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int MODE_POS = 4,
  parameter int RDY_POS  = 7
) (
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output cfg_cmd_e         cmd
);

  logic mode_bit;
  logic start_bit;
  logic unused_cfg_bits;

  assign mode_bit        = cfg_wdata[MODE_POS];
  assign start_bit       = cfg_wdata[RDY_POS];
  assign unused_cfg_bits = ^cfg_wdata;

  always_comb begin
    if (!cfg_wr)        cmd = CMD_NONE;
    else if (mode_bit)  cmd = CMD_CONT;
    else if (start_bit) cmd = CMD_ONESHOT;
    else                cmd = CMD_KEEP;
  end

endmodule

// File: rtl/convmode_state.sv
module convmode_state
  import convmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cfg_cmd_e cmd,
  input  logic     conv_done,
  input  logic     rd_done,
  output logic     mode_next,
  output logic     mode_cont,
  output logic     rdy
);

  logic rdy_next;

  always_comb begin
    case (cmd)
      CMD_CONT:              mode_next = 1'b1;
      CMD_ONESHOT, CMD_KEEP: mode_next = 1'b0;
      default:               mode_next = mode_cont;
    endcase
  end

  // Start command wins, then a fresh result, then consumption in continuous mode.
  always_comb begin
    if (cmd_starts(cmd))            rdy_next = 1'b1;
    else if (conv_done)             rdy_next = 1'b0;
    else if (rd_done && mode_next)  rdy_next = 1'b1;
    else                            rdy_next = rdy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_cont <= 1'b1;
      rdy       <= 1'b1;
    end else begin
      mode_cont <= mode_next;
      rdy       <= rdy_next;
    end
  end

endmodule

// File: rtl/convmode_result_reg.sv
module convmode_result_reg #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] result
);

  always_ff @(posedge clk) begin
    if (!rst_n)         result <= '0;
    else if (conv_done) result <= conv_data;
  end

endmodule

// File: rtl/convmode_start_gen.sv
module convmode_start_gen
  import convmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cfg_cmd_e cmd,
  input  logic     conv_done,
  input  logic     mode_next,
  output logic     conv_start
);

  logic kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kick_q     <= 1'b1;
      conv_start <= 1'b0;
    end else begin
      kick_q     <= 1'b0;
      conv_start <= kick_q | cmd_starts(cmd) | (conv_done & mode_next);
    end
  end

endmodule

// File: rtl/convmode_ctrl.sv
module convmode_ctrl
  import convmode_pkg::*;
#(
  parameter int RES_W    = 18,
  parameter int CFG_W    = 8,
  parameter int MODE_POS = 4,
  parameter int RDY_POS  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rd_done,
  output logic             conv_start,
  output logic [RES_W-1:0] result,
  output logic             mode_cont,
  output logic             rdy
);

  cfg_cmd_e cmd;
  logic     mode_next;

  convmode_cfg_decode #(
    .CFG_W    (CFG_W),
    .MODE_POS (MODE_POS),
    .RDY_POS  (RDY_POS)
  ) u_decode (
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cmd       (cmd)
  );

  convmode_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .conv_done (conv_done),
    .rd_done   (rd_done),
    .mode_next (mode_next),
    .mode_cont (mode_cont),
    .rdy       (rdy)
  );

  convmode_result_reg #(
    .RES_W (RES_W)
  ) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .result    (result)
  );

  convmode_start_gen u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .conv_done  (conv_done),
    .mode_next  (mode_next),
    .conv_start (conv_start)
  );

endmodule

// File: rtl/convmode_ctrl_chk.sv
module convmode_ctrl_chk #(
  parameter int RES_W    = 18,
  parameter int CFG_W    = 8,
  parameter int MODE_POS = 4,
  parameter int RDY_POS  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_data,
  input logic             rd_done,
  input logic             conv_start,
  input logic [RES_W-1:0] result,
  input logic             mode_cont,
  input logic             rdy
);

  logic wr_cont, wr_one, wr_keep, quiet;

  assign wr_cont = cfg_wr &&  cfg_wdata[MODE_POS];
  assign wr_one  = cfg_wr && !cfg_wdata[MODE_POS] &&  cfg_wdata[RDY_POS];
  assign wr_keep = cfg_wr && !cfg_wdata[MODE_POS] && !cfg_wdata[RDY_POS];
  assign quiet   = !cfg_wr && !conv_done && !rd_done;

  a_r2_cont_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cont |=> (mode_cont && rdy && conv_start));

  a_r3_oneshot_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_one |=> (!mode_cont && rdy && conv_start));

  a_r4_keep_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_keep && !mode_cont && !conv_done && !rd_done)
      |=> (!mode_cont && $stable(rdy) && $stable(result) && !conv_start));

  a_r5_result_capture: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (result == $past(conv_data)));

  a_r6_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && mode_cont && !cfg_wr) |=> (conv_start && !rdy));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !mode_cont && !cfg_wr) |=> !conv_start);

  a_r7_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !mode_cont && !conv_done && !cfg_wr) |=> $stable(rdy));

  a_r8_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && mode_cont && !conv_done && !cfg_wr) |=> rdy);

  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rd_done && !cfg_wr) |=> !rdy);

  a_r10_cmd_over_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_cont || wr_one) && conv_done) |=> rdy);

  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && $past(rst_n)) |=> ($stable(rdy) && $stable(mode_cont) && $stable(result) && !conv_start));

endmodule

bind convmode_ctrl convmode_ctrl_chk #(
  .RES_W    (RES_W),
  .CFG_W    (CFG_W),
  .MODE_POS (MODE_POS),
  .RDY_POS  (RDY_POS)
) u_chk (.*);

// File: tb/convmode_ctrl_tb.sv
module convmode_ctrl_tb;

  localparam int RES_W = 18;
  localparam int CFG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic             rd_done = 1'b0;
  logic             conv_start;
  logic [RES_W-1:0] result;
  logic             mode_cont;
  logic             rdy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic             m_mode, m_rdy, m_start, m_kick;
  logic [RES_W-1:0] m_res;

  always #10 clk = ~clk;

  convmode_ctrl #(.RES_W(RES_W), .CFG_W(CFG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .conv_done(conv_done), .conv_data(conv_data), .rd_done(rd_done),
    .conv_start(conv_start), .result(result), .mode_cont(mode_cont), .rdy(rdy)
  );

  task automatic compare(input string tag);
    checks++;
    if (conv_start !== m_start || result !== m_res || mode_cont !== m_mode || rdy !== m_rdy) begin
      errors++;
      $display("FAIL %s: start=%b res=%h mode=%b rdy=%b expected start=%b res=%h mode=%b rdy=%b",
               tag, conv_start, result, mode_cont, rdy, m_start, m_res, m_mode, m_rdy);
    end
  endtask

  // Compute the reference next state from the requirements.
  task automatic model(input logic wr, input logic [CFG_W-1:0] wd, input logic done,
                       input logic [RES_W-1:0] data, input logic rd);
    logic is_cont, is_one, is_keep, nmode;
    is_cont = wr && wd[4];
    is_one  = wr && !wd[4] && wd[7];
    is_keep = wr && !wd[4] && !wd[7];
    nmode   = is_cont ? 1'b1 : ((is_one || is_keep) ? 1'b0 : m_mode);
    m_start = m_kick || is_cont || is_one || (done && nmode);
    if (is_cont || is_one) m_rdy = 1'b1;
    else if (done)         m_rdy = 1'b0;
    else if (rd && nmode)  m_rdy = 1'b1;
    if (done) m_res = data;
    m_mode = nmode;
    m_kick = 1'b0;
  endtask

  function automatic string pick_tag(input logic wr, input logic [CFG_W-1:0] wd,
                                     input logic done, input logic rd);
    if (wr && (wd[4] || wd[7])) return done ? "R10" : (wd[4] ? "R2" : "R3");
    if (wr)          return "R4";
    if (done && rd)  return "R9";
    if (done)        return m_mode ? "R6" : "R5";
    if (rd)          return m_mode ? "R8" : "R7";
    return "R11";
  endfunction

  task automatic step(input logic wr, input logic [CFG_W-1:0] wd, input logic done,
                      input logic [RES_W-1:0] data, input logic rd, input string tag);
    cfg_wr = wr; cfg_wdata = wd; conv_done = done; conv_data = data; rd_done = rd;
    model(wr, wd, done, data, rd);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    m_mode = 1'b1; m_rdy = 1'b1; m_res = '0; m_start = 1'b0; m_kick = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    step(0, 8'h00, 0, '0, 0, "R1 start after reset");
    step(0, 8'h00, 0, '0, 0, "R11 idle");

    // continuous: result then read
    step(0, 8'h00, 1, 18'h2ABCD, 0, "R6 done in continuous");
    step(0, 8'h00, 0, '0, 1, "R8 read sets rdy");
    step(0, 8'h00, 1, 18'h00011, 1, "R9 done and read together");
    // R2 with bit7 both values
    step(1, 8'h10, 0, '0, 0, "R2 continuous bit7=0");
    step(1, 8'h90, 0, '0, 0, "R2 continuous bit7=1");
    // one-shot
    step(1, 8'h80, 0, '0, 0, "R3 one-shot start");
    step(0, 8'h00, 0, '0, 1, "R7 read during one-shot");
    step(0, 8'h00, 1, 18'h3FFFF, 0, "R7 one-shot done no restart");
    step(0, 8'h00, 0, '0, 1, "R7 read keeps rdy low");
    step(1, 8'h00, 0, '0, 0, "R4 keep write in one-shot");
    step(1, 8'h6F, 0, '0, 0, "R4 keep write other bits");
    step(1, 8'h80, 1, 18'h12345, 0, "R10 start with done");
    step(1, 8'h10, 1, 18'h0F0F0, 1, "R10 continuous with done");
    step(1, 8'h00, 0, '0, 0, "R4 leave continuous without start");
    step(0, 8'h00, 1, 18'h00001, 0, "R5 done after keep write");

    for (int i = 0; i < 3000; i++) begin
      logic wr, done, rd;
      logic [CFG_W-1:0] wd;
      logic [RES_W-1:0] data;
      wr   = ($urandom % 8) == 0;
      done = ($urandom % 4) == 0;
      rd   = ($urandom % 4) == 0;
      wd   = CFG_W'($urandom);
      data = RES_W'($urandom);
      step(wr, wd, done, data, rd, pick_tag(wr, wd, done, rd));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule